// File: doc/BRIEF.md
# Standby-Capable UTOPIA Receive Cell Gate

This block is the last stage of an ATM PHY's receive path. Bytes of complete cells arrive from an upstream cell source. They are stored in a small cell FIFO, and the ATM layer then reads them out over an 8-bit UTOPIA Level 2 style receive interface. That interface carries data, odd parity, start-of-cell and cell-available. The ATM layer pulls one byte per clock while its read enable is high.

A single configuration bit puts the block into standby. This allows a primary and a backup PHY to share one bus address. In standby, the receive data, parity, start-of-cell and cell-available outputs are released, and so is the transmit-side cell-available pin. Each pin group has its own output enable next to its driven value. Arriving cells are still accepted at full rate. Once four complete cells are stored, each new arrival evicts the oldest whole cell, so the FIFO always holds the most recent cells. When software clears the bit, the retained cells are delivered at once, with no FIFO reset. A change of the bit in the middle of an outgoing cell waits until that cell has been fully read.

Top module: `urxg_gate`

## Requirements
- R1: After reset the block is enabled. Writing 1 through `cfg_we`/`cfg_standby` requests standby, and writing 0 requests enable.
- R2: While enabled, all five output enables (`rx_data_oe`, `rx_prty_oe`, `rx_soc_oe`, `rx_clav_oe`, `tx_clav_oe`) are 1. While in standby, all five are 0.
- R3: `rx_clav` is 1 only while at least one complete 53-byte cell is stored. A byte is consumed only on a clock with `atm_rd_en` high while enabled. With `atm_rd_en` low, or in standby, the presented byte holds.
- R4: Cells leave in arrival order, with their bytes in arrival order. `rx_soc` is 1 exactly while byte 0 of a cell is presented.
- R5: `rx_prty` is odd parity over `rx_data`: the 9 bits together hold an odd number of ones.
- R6: A standby request written while an outgoing cell is partly read takes effect only after the cell's last byte is consumed. Until then the output enables stay 1 and reading continues.
- R7: In standby, arriving cells are still accepted. When a cell completes with KEEP (4) complete cells already stored, the oldest stored cell is discarded whole.
- R8: On return to enabled, the retained cells are delivered oldest first without any reset, and `rx_clav` is 1 immediately.
- R9: While enabled, a cell that begins when all DEPTH (5) slots hold complete cells is discarded whole. The stored cells are unaffected.
- R10: `tx_clav` follows `tx_clav_in` in both modes. Only its enable follows the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the standby bit |
| cfg_standby | input | 1 | Standby bit value (1 = standby, 0 = enabled) |
| cell_valid | input | 1 | Upstream byte valid |
| cell_data | input | 8 | Upstream cell byte |
| cell_soc | input | 1 | Upstream byte is the first of a cell |
| atm_rd_en | input | 1 | ATM-layer read enable, active high |
| tx_clav_in | input | 1 | Transmit cell-available from the transmit path |
| rx_data | output | 8 | Receive data |
| rx_data_oe | output | 1 | Output enable for rx_data |
| rx_prty | output | 1 | Odd parity of rx_data |
| rx_prty_oe | output | 1 | Output enable for rx_prty |
| rx_soc | output | 1 | Start-of-cell marker |
| rx_soc_oe | output | 1 | Output enable for rx_soc |
| rx_clav | output | 1 | Receive cell-available |
| rx_clav_oe | output | 1 | Output enable for rx_clav |
| tx_clav | output | 1 | Transmit cell-available, passed through |
| tx_clav_oe | output | 1 | Output enable for tx_clav |

## Verification
Several properties are checked on every cycle. The stored-cell count never exceeds the slot count. A cell completing in standby with KEEP cells stored leaves the count unchanged. The effective mode changes only at a cell boundary, no byte advances in standby, and start-of-cell is never shown without cell-available. Other behaviour can only be shown by the bench's scenarios, because it concerns which data comes out. That covers byte order and parity, which four cells survive a standby period, and the delivery of those cells after re-enable. It also covers dropping a cell on overflow while enabled, and a mid-cell standby request that lets the current cell finish.

// File: rtl/urxg_pkg.sv
package urxg_pkg;
   // odd parity bit for one bus byte: byte plus bit carries an odd count of ones
   function automatic logic odd_par(input logic [7:0] d);
      return ~(^d);
   endfunction
endpackage

// File: rtl/urxg_cell_mem.sv
module urxg_cell_mem #(
   parameter int W          = 8,
   parameter int DEPTH      = 5,
   parameter int CELL_BYTES = 53,
   localparam int SW   = $clog2(DEPTH),
   localparam int BW   = $clog2(CELL_BYTES),
   localparam int SIZE = DEPTH * CELL_BYTES,
   localparam int AW   = $clog2(SIZE)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [SW-1:0] wslot,
   input  logic [BW-1:0] wbyte,
   input  logic [W-1:0]  wdata,
   input  logic [SW-1:0] rslot,
   input  logic [BW-1:0] rbyte,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [SIZE];
   logic [AW-1:0] waddr, raddr;

   assign waddr = AW'(int'(wslot) * CELL_BYTES + int'(wbyte));
   assign raddr = AW'(int'(rslot) * CELL_BYTES + int'(rbyte));

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   assign rdata = store[raddr];
endmodule

// File: rtl/urxg_ctrl.sv
module urxg_ctrl #(
   parameter int DEPTH      = 5,
   parameter int KEEP       = 4,
   parameter int CELL_BYTES = 53,
   localparam int SW = $clog2(DEPTH),
   localparam int BW = $clog2(CELL_BYTES),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic          cfg_standby,
   input  logic          cell_valid,
   input  logic          cell_soc,
   input  logic          atm_rd_en,
   output logic          wr_en,
   output logic [SW-1:0] wr_slot,
   output logic [BW-1:0] wr_byte,
   output logic [SW-1:0] rd_slot,
   output logic [BW-1:0] rd_byte,
   output logic          rd_first,
   output logic          have_cell,
   output logic          sby_eff
);
   if (DEPTH < 2)       begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (KEEP < 1)        begin : g_bad_keep  $error("KEEP must be at least 1"); end
   if (KEEP >= DEPTH)   begin : g_bad_ratio $error("KEEP must be below DEPTH"); end
   if (CELL_BYTES < 2)  begin : g_bad_cell  $error("CELL_BYTES must be at least 2"); end

   logic          standby_req, sby_q;
   logic [SW-1:0] wslot_q, rslot_q;
   logic [BW-1:0] wbyte_q, rbyte_q, wbyte_cur;
   logic [CW-1:0] cnt_q;
   logic          wbusy_q, wdrop_q;
   logic          full, in_start, in_take, in_last, drop_now;
   logic          wr_done, drop_start, drop_done, rd_xfer, rd_last, pop;

   function automatic logic [SW-1:0] nxt(input logic [SW-1:0] s);
      return (s == SW'(DEPTH - 1)) ? '0 : s + 1'b1;
   endfunction

   always_comb begin
      rd_first   = (rbyte_q == '0);
      sby_eff    = rd_first ? standby_req : sby_q;
      full       = (cnt_q == CW'(DEPTH));
      in_start   = cell_valid & cell_soc;
      in_take    = cell_valid & (cell_soc | wbusy_q);
      wbyte_cur  = cell_soc ? '0 : wbyte_q;
      drop_now   = in_start ? (full & ~sby_eff) : wdrop_q;
      wr_en      = in_take & ~drop_now;
      in_last    = in_take & (wbyte_cur == BW'(CELL_BYTES - 1));
      wr_done    = wr_en & in_last;
      drop_start = in_start & sby_eff & full;
      drop_done  = wr_done & sby_eff & (cnt_q >= CW'(KEEP));
      rd_xfer    = ~sby_eff & atm_rd_en & (cnt_q != '0);
      rd_last    = rd_xfer & (rbyte_q == BW'(CELL_BYTES - 1));
      pop        = rd_last | drop_start | drop_done;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         standby_req <= 1'b0;
         sby_q       <= 1'b0;
         wslot_q     <= '0;
         rslot_q     <= '0;
         wbyte_q     <= '0;
         rbyte_q     <= '0;
         cnt_q       <= '0;
         wbusy_q     <= 1'b0;
         wdrop_q     <= 1'b0;
      end else begin
         if (cfg_we) standby_req <= cfg_standby;
         sby_q <= sby_eff;
         if (in_take) begin
            wbusy_q <= ~in_last;
            wbyte_q <= in_last ? '0 : wbyte_cur + 1'b1;
         end
         if (in_start) wdrop_q <= full & ~sby_eff;
         if (wr_done)  wslot_q <= nxt(wslot_q);
         if (pop)      rslot_q <= nxt(rslot_q);
         if (rd_xfer)  rbyte_q <= rd_last ? '0 : rbyte_q + 1'b1;
         cnt_q <= cnt_q + CW'(wr_done) - CW'(pop);
      end
   end

   assign wr_slot   = wslot_q;
   assign wr_byte   = wbyte_cur;
   assign rd_slot   = rslot_q;
   assign rd_byte   = rbyte_q;
   assign have_cell = (cnt_q != '0);

   a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   a_r7_keep_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_done && sby_eff && cnt_q >= CW'(KEEP)) |=> cnt_q == $past(cnt_q));
   a_r6_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (sby_q != $past(sby_q)) |-> $past(rd_first));
   a_r3_no_read_standby: assert property (@(posedge clk) disable iff (!rst_n)
      sby_eff |=> rbyte_q == '0);
endmodule

// File: rtl/urxg_pins.sv
module urxg_pins #(
   parameter int NGRP = 5
) (
   input  logic       rst_n,
   input  logic       clk,
   input  logic [7:0] rdata,
   input  logic       rd_first,
   input  logic       have_cell,
   input  logic       sby_eff,
   input  logic       tx_clav_in,
   output logic [7:0] rx_data,
   output logic       rx_prty,
   output logic       rx_soc,
   output logic       rx_clav,
   output logic       tx_clav,
   output logic [NGRP-1:0] oe_vec
);
   import urxg_pkg::*;

   if (NGRP != 5) begin : g_bad_grp $error("five pin groups expected"); end

   for (genvar g = 0; g < NGRP; g++) begin : g_oe
      assign oe_vec[g] = ~sby_eff;
   end

   assign rx_data = rdata;
   assign rx_prty = odd_par(rdata);
   assign rx_clav = have_cell;
   assign rx_soc  = have_cell & rd_first;
   assign tx_clav = tx_clav_in;

   a_r4_soc_needs_clav: assert property (@(posedge clk) disable iff (!rst_n)
      rx_soc |-> rx_clav);
endmodule

// File: rtl/urxg_gate.sv
module urxg_gate #(
   parameter int DEPTH      = 5,
   parameter int KEEP       = 4,
   parameter int CELL_BYTES = 53
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_we,
   input  logic       cfg_standby,
   input  logic       cell_valid,
   input  logic [7:0] cell_data,
   input  logic       cell_soc,
   input  logic       atm_rd_en,
   input  logic       tx_clav_in,
   output logic [7:0] rx_data,
   output logic       rx_data_oe,
   output logic       rx_prty,
   output logic       rx_prty_oe,
   output logic       rx_soc,
   output logic       rx_soc_oe,
   output logic       rx_clav,
   output logic       rx_clav_oe,
   output logic       tx_clav,
   output logic       tx_clav_oe
);
   localparam int SW = $clog2(DEPTH);
   localparam int BW = $clog2(CELL_BYTES);

   logic          wr_en, rd_first, have_cell, sby_eff;
   logic [SW-1:0] wr_slot, rd_slot;
   logic [BW-1:0] wr_byte, rd_byte;
   logic [7:0]    rdata;
   logic [4:0]    oe_vec;

   urxg_ctrl #(.DEPTH(DEPTH), .KEEP(KEEP), .CELL_BYTES(CELL_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_standby(cfg_standby),
      .cell_valid(cell_valid), .cell_soc(cell_soc), .atm_rd_en(atm_rd_en),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_byte(wr_byte),
      .rd_slot(rd_slot), .rd_byte(rd_byte), .rd_first(rd_first),
      .have_cell(have_cell), .sby_eff(sby_eff));

   urxg_cell_mem #(.W(8), .DEPTH(DEPTH), .CELL_BYTES(CELL_BYTES)) u_mem (
      .clk(clk), .we(wr_en), .wslot(wr_slot), .wbyte(wr_byte), .wdata(cell_data),
      .rslot(rd_slot), .rbyte(rd_byte), .rdata(rdata));

   urxg_pins #(.NGRP(5)) u_pins (
      .rst_n(rst_n), .clk(clk), .rdata(rdata), .rd_first(rd_first),
      .have_cell(have_cell), .sby_eff(sby_eff), .tx_clav_in(tx_clav_in),
      .rx_data(rx_data), .rx_prty(rx_prty), .rx_soc(rx_soc), .rx_clav(rx_clav),
      .tx_clav(tx_clav), .oe_vec(oe_vec));

   assign rx_data_oe = oe_vec[0];
   assign rx_prty_oe = oe_vec[1];
   assign rx_soc_oe  = oe_vec[2];
   assign rx_clav_oe = oe_vec[3];
   assign tx_clav_oe = oe_vec[4];

   a_r2_clav_released: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_clav_oe) && !rx_clav_oe |-> $past(rd_first) || rd_first);
endmodule

// File: tb/urxg_gate_test.sv
module urxg_gate_test;
   localparam int NB = 53;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 1'b0, cfg_standby = 1'b0;
   logic cell_valid = 1'b0, cell_soc = 1'b0, atm_rd_en = 1'b0, tx_clav_in = 1'b0;
   logic [7:0] cell_data = '0;
   logic [7:0] rx_data;
   logic rx_data_oe, rx_prty, rx_prty_oe, rx_soc, rx_soc_oe;
   logic rx_clav, rx_clav_oe, tx_clav, tx_clav_oe;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   urxg_gate uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_standby(cfg_standby),
      .cell_valid(cell_valid), .cell_data(cell_data), .cell_soc(cell_soc),
      .atm_rd_en(atm_rd_en), .tx_clav_in(tx_clav_in),
      .rx_data(rx_data), .rx_data_oe(rx_data_oe), .rx_prty(rx_prty),
      .rx_prty_oe(rx_prty_oe), .rx_soc(rx_soc), .rx_soc_oe(rx_soc_oe),
      .rx_clav(rx_clav), .rx_clav_oe(rx_clav_oe), .tx_clav(tx_clav),
      .tx_clav_oe(tx_clav_oe));

   // stimulus table: cell seed and idle cycles (read enable low) before reading
   localparam int NV = 4;
   localparam int VEC_SEED [NV] = '{3, 90, 155, 201};
   localparam int VEC_IDLE [NV] = '{0, 3, 1, 6};

   function automatic logic [7:0] exp_byte(input int seed, input int i);
      return 8'(seed * 37 + i);
   endfunction

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [4:0] oes();
      return {rx_data_oe, rx_prty_oe, rx_soc_oe, rx_clav_oe, tx_clav_oe};
   endfunction

   task automatic push_bytes(input int seed, input int from, input int upto);
      for (int i = from; i <= upto; i++) begin
         @(negedge clk);
         cell_valid = 1'b1;
         cell_soc   = (i == 0);
         cell_data  = exp_byte(seed, i);
      end
      @(negedge clk);
      cell_valid = 1'b0;
      cell_soc   = 1'b0;
   endtask

   task automatic write_cfg(input logic v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_standby = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // reads bytes from..upto of a cell; caller is at a negedge afterwards
   task automatic pop_bytes(input int seed, input int from, input int upto, input string req);
      int bad = 0;
      for (int i = from; i <= upto; i++) begin
         @(negedge clk);
         if (rx_data !== exp_byte(seed, i) || rx_soc !== (i == 0) ||
             rx_prty !== ~(^exp_byte(seed, i)) || rx_clav !== 1'b1) begin
            bad++;
            if (bad == 1)
               $display("FAIL %s byte %0d actual=%0d expected=%0d", req, i,
                        rx_data, exp_byte(seed, i));
         end
         atm_rd_en = 1'b1;
      end
      @(negedge clk);
      atm_rd_en = 1'b0;
      checks++;
      if (bad != 0) failures++;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R2: reset state is enabled, all enables on; R3: no cell
      chk(oes() == 5'b11111, "R1 reset enables", oes(), 31);
      chk(rx_clav == 1'b0, "R3 reset clav", rx_clav, 0);

      // table walk: R3 R4 R5 in enabled mode
      for (int v = 0; v < NV; v++) begin
         push_bytes(VEC_SEED[v], 0, NB - 1);
         chk(rx_clav == 1'b1, "R3 clav after cell", rx_clav, 1);
         repeat (VEC_IDLE[v]) @(negedge clk);
         chk(rx_data == exp_byte(VEC_SEED[v], 0) && rx_soc, "R3 hold without read",
             rx_data, exp_byte(VEC_SEED[v], 0));
         pop_bytes(VEC_SEED[v], 0, NB - 1, "R4 R5 table cell");
         chk(rx_clav == 1'b0, "R3 clav drops when empty", rx_clav, 0);
      end

      // R3: partial cell does not raise clav
      push_bytes(20, 0, NB - 2);
      chk(rx_clav == 1'b0, "R3 partial cell", rx_clav, 0);
      push_bytes(20, NB - 1, NB - 1);
      chk(rx_clav == 1'b1, "R3 completed cell", rx_clav, 1);
      pop_bytes(20, 0, NB - 1, "R4 split-written cell");

      // R9: sixth cell dropped while enabled and full
      for (int k = 0; k < 6; k++) push_bytes(40 + k, 0, NB - 1);
      for (int k = 0; k < 5; k++) pop_bytes(40 + k, 0, NB - 1, "R9 stored cells intact");
      chk(rx_clav == 1'b0, "R9 overflow cell discarded", rx_clav, 0);

      // R10: transmit clav passthrough while enabled
      tx_clav_in = 1'b1;
      @(negedge clk);
      chk(tx_clav == 1'b1 && tx_clav_oe == 1'b1, "R10 tx clav enabled", tx_clav, 1);

      // R6: standby written mid-cell waits for the cell boundary
      push_bytes(50, 0, NB - 1);
      push_bytes(51, 0, NB - 1);
      pop_bytes(50, 0, 9, "R6 first part");
      write_cfg(1'b1);
      chk(oes() == 5'b11111, "R6 enables held mid-cell", oes(), 31);
      pop_bytes(50, 10, NB - 1, "R6 rest of cell");
      chk(oes() == 5'b00000, "R2 R6 standby after boundary", oes(), 0);
      chk(tx_clav == 1'b1, "R10 tx clav value in standby", tx_clav, 1);

      // R3: reads ignored in standby, presented byte holds
      atm_rd_en = 1'b1;
      repeat (8) @(negedge clk);
      atm_rd_en = 1'b0;

      // R7: arrivals continue, only the last four survive
      for (int k = 0; k < 5; k++) push_bytes(60 + k, 0, NB - 1);
      chk(oes() == 5'b00000, "R2 still released", oes(), 0);

      // R8: re-enable delivers 61..64 without reset
      write_cfg(1'b0);
      chk(oes() == 5'b11111 && rx_clav == 1'b1, "R1 R8 re-enabled with cells",
          {oes(), rx_clav}, 63);
      for (int k = 1; k < 5; k++) pop_bytes(60 + k, 0, NB - 1, "R7 R8 retained cell");
      chk(rx_clav == 1'b0, "R7 older cells discarded", rx_clav, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule